// File: doc/BRIEF.md
# Reset Cause Controller

This block collects the internal reset requests of a small microcontroller and turns the winning one into a single system reset pulse. There are four sources: an armed comparator whose output shows the non-inverting input below the inverting input, a watchdog timeout strobe, an illegal flash access, and a software write. The illegal-access check is built in. It compares each flash access against the top of the user code space and against a security-block flag.

A byte-wide status register shows which source caused the latest internal reset. That flag is captured on the clock where the request is first seen, and it stays readable through the pulse and after it. Software uses a write port to arm the comparator source and to force a reset. Arming only takes effect once the comparator has reported itself settled for at least `SETTLE` clocks.

After every reset the block enables the watchdog and supplies it with a one-in-`WDT_DIV` clock enable. None of the internal sources touches the external reset pin, so the block has no pin output.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_i` is high, `status_o` reads 0x00 and `sys_rst_o` is high. After `por_i` falls, `sys_rst_o` stays high for `PULSE` more clocks.
- R2: A reset request accepted on a clock edge raises `sys_rst_o` from that edge onward for exactly `PULSE` clocks (default 16).
- R3: An illegal flash access triggers a reset with status 0x40 (bit 6). The `fl_kind_i` encoding is 0 = data write/erase, 1 = code-space read, 2 = instruction fetch, 3 = none. An access is illegal when `fl_valid_i` is high, the kind is 1 or 2 (or kind 0 with `fl_wen_i` high), and either the address is above `CODE_TOP` (default 0x1DFF) or `fl_secure_i` is high.
- R4: A `wdt_timeout_i` strobe triggers a reset with status 0x08 (bit 3).
- R5: A register write with data bit 4 set triggers a reset with status 0x10 (bit 4).
- R6: A register write with data bit 5 set arms the comparator source, but only if `cmp_ready_i` was high on at least `SETTLE` previous clock edges. Otherwise the write does not arm it. While the source is armed and settled, `cmp_out_i` low triggers a reset with status 0x20 (bit 5). Any reset disarms the source.
- R7: After an internal reset exactly one status bit is set and all the others are cleared. When requests coincide, the priority is flash error, then watchdog, then software, then comparator.
- R8: Status bits 0-2 and 7 always read 0. Register writes never change the status byte directly, so a write of 0xCF leaves it unchanged and causes no reset.
- R9: While `sys_rst_o` is high, new requests and register writes are ignored. The status byte holds its value and no second pulse follows.
- R10: `wdt_en_o` is low while `sys_rst_o` is high and high otherwise. `wdt_tick_o` pulses for one clock on every `WDT_DIV`-th enabled clock, first on the `WDT_DIV`-th clock after release.
- R11: Legal accesses cause no reset. These include a fetch at 0x1DFF and a data write with `fl_wen_i` low at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Synchronous active-high power-on reset |
| cmp_out_i | input | 1 | Comparator output, low when non-inverting input is below inverting input |
| cmp_ready_i | input | 1 | Comparator enabled and settled |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe |
| fl_valid_i | input | 1 | Flash access attempt this cycle |
| fl_kind_i | input | 2 | Access kind: 0 data write/erase, 1 code read, 2 fetch, 3 none |
| fl_wen_i | input | 1 | Flash write enable for data writes |
| fl_addr_i | input | ADDR_W | Flash target address |
| fl_secure_i | input | 1 | Access blocked by security setting |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| sys_rst_o | output | 1 | System reset pulse |
| status_o | output | 8 | Reset cause byte |
| wdt_en_o | output | 1 | Watchdog enable |
| wdt_tick_o | output | 1 | Watchdog clock enable, one in WDT_DIV |

## Verification
The bench builds the block with its default parameters: a 16-clock pulse, a divide-by-12 watchdog tick, a two-clock settle window and a code-space top of 0x1DFF. With these values the exact pulse length, two full tick periods after release, and the one-edge-short arming attempt are all observable. The same values put accesses just on either side of the address boundary within reach. A behavioural model in the bench tracks every output each clock. Directed sequences also cover coinciding requests, requests arriving mid-pulse, and comparator arming before and after settling.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        ACC_DATA_WR = 2'd0,
        ACC_CODE_RD = 2'd1,
        ACC_FETCH   = 2'd2,
        ACC_NONE    = 2'd3
    } acc_kind_e;

    localparam int unsigned BIT_WDT   = 3;
    localparam int unsigned BIT_SW    = 4;
    localparam int unsigned BIT_CMP   = 5;
    localparam int unsigned BIT_FLASH = 6;

    typedef struct packed {
        logic flash;
        logic wdt;
        logic sw;
        logic cmp;
    } req_vec_t;

    function automatic logic any_req(req_vec_t r);
        return r.flash | r.wdt | r.sw | r.cmp;
    endfunction

    // Fixed priority: flash error, watchdog, software, comparator.
    function automatic logic [7:0] cause_byte(req_vec_t r);
        logic [7:0] b;
        b = '0;
        if (r.flash)     b[BIT_FLASH] = 1'b1;
        else if (r.wdt)  b[BIT_WDT]   = 1'b1;
        else if (r.sw)   b[BIT_SW]    = 1'b1;
        else if (r.cmp)  b[BIT_CMP]   = 1'b1;
        return b;
    endfunction

endpackage

// File: rtl/rstc_flash_chk.sv
module rstc_flash_chk
    import rstc_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]    CODE_TOP = 16'h1DFF
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              valid_i,
    input  logic [1:0]        kind_i,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              secure_i,
    output logic              illegal_o
);
    acc_kind_e kind;
    logic      touches;
    logic      beyond;

    always_comb begin
        kind = acc_kind_e'(kind_i);
        unique case (kind)
            ACC_DATA_WR: touches = wen_i;
            ACC_CODE_RD: touches = 1'b1;
            ACC_FETCH:   touches = 1'b1;
            default:     touches = 1'b0;
        endcase
        beyond    = (addr_i > CODE_TOP);
        illegal_o = valid_i && touches && (beyond || secure_i);
    end

    // R11: an unsecured access inside code space never flags an error
    p_legal_inside_r11: assert property (@(posedge clk) disable iff (por_i)
        (valid_i && !secure_i && addr_i <= CODE_TOP) |-> !illegal_o);

    // R11: a data write without write enable never flags an error
    p_no_wen_r11: assert property (@(posedge clk) disable iff (por_i)
        (kind_i == 2'd0 && !wen_i) |-> !illegal_o);

endmodule

// File: rtl/rstc_cmp_gate.sv
module rstc_cmp_gate #(
    parameter int unsigned SETTLE = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic clr_i,
    input  logic accept_i,
    input  logic ready_i,
    input  logic cmp_i,
    input  logic wr_i,
    input  logic wr_arm_i,
    output logic req_o
);
    localparam int unsigned CW = $clog2(SETTLE + 1);

    logic [CW-1:0] settle_q;
    logic          settled;
    logic          arm_q;

    assign settled = (settle_q >= CW'(SETTLE));

    always_ff @(posedge clk) begin
        if (por_i || !ready_i) begin
            settle_q <= '0;
        end else if (!settled) begin
            settle_q <= settle_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (por_i || clr_i) begin
            arm_q <= 1'b0;
        end else if (accept_i && wr_i) begin
            if (!wr_arm_i)      arm_q <= 1'b0;
            else if (settled)   arm_q <= 1'b1;
        end
    end

    // Comparator reset condition is active-low
    assign req_o = arm_q && settled && !cmp_i;

    // R6: arming only follows a settled comparator
    p_arm_settled_r6: assert property (@(posedge clk) disable iff (por_i)
        $rose(arm_q) |-> $past(settled));

    // R6: dropping the ready indication removes any request at once
    p_ready_gate_r6: assert property (@(posedge clk) disable iff (por_i)
        !ready_i |=> !req_o);

endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse #(
    parameter int unsigned PULSE   = 16,
    parameter int unsigned WDT_DIV = 12
) (
    input  logic clk,
    input  logic por_i,
    input  logic start_i,
    output logic rst_o,
    output logic wdt_en_o,
    output logic tick_o
);
    localparam int unsigned CNT_W = $clog2(PULSE + 1);
    localparam int unsigned DIV_W = (WDT_DIV > 1) ? $clog2(WDT_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(WDT_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;

    assign rst_o    = (cnt_q != '0);
    assign wdt_en_o = !rst_o;
    assign tick_o   = wdt_en_o && (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (por_i) begin
            cnt_q <= CNT_W'(PULSE);
        end else if (rst_o) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (start_i) begin
            cnt_q <= CNT_W'(PULSE);
        end
    end

    always_ff @(posedge clk) begin
        if (por_i || rst_o) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // R2: an accepted request loads the full pulse length
    p_pulse_start_r2: assert property (@(posedge clk) disable iff (por_i)
        (start_i && !rst_o) |=> (rst_o && cnt_q == CNT_W'(PULSE)));

    // R10: a tick lasts a single clock
    p_tick_single_r10: assert property (@(posedge clk) disable iff (por_i)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CODE_TOP = 16'h1DFF,
    parameter int unsigned       PULSE    = 16,
    parameter int unsigned       WDT_DIV  = 12,
    parameter int unsigned       SETTLE   = 2
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              cmp_out_i,
    input  logic              cmp_ready_i,
    input  logic              wdt_timeout_i,
    input  logic              fl_valid_i,
    input  logic [1:0]        fl_kind_i,
    input  logic              fl_wen_i,
    input  logic [ADDR_W-1:0] fl_addr_i,
    input  logic              fl_secure_i,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic              sys_rst_o,
    output logic [7:0]        status_o,
    output logic              wdt_en_o,
    output logic              wdt_tick_o
);
    req_vec_t   req;
    logic       busy;
    logic       start;
    logic       fl_err;
    logic       cmp_req;
    logic [7:0] status_q;

    rstc_flash_chk #(.ADDR_W(ADDR_W), .CODE_TOP(CODE_TOP)) u_flash (
        .clk       (clk),
        .por_i     (por_i),
        .valid_i   (fl_valid_i),
        .kind_i    (fl_kind_i),
        .wen_i     (fl_wen_i),
        .addr_i    (fl_addr_i),
        .secure_i  (fl_secure_i),
        .illegal_o (fl_err)
    );

    rstc_cmp_gate #(.SETTLE(SETTLE)) u_cmp (
        .clk      (clk),
        .por_i    (por_i),
        .clr_i    (start),
        .accept_i (!busy),
        .ready_i  (cmp_ready_i),
        .cmp_i    (cmp_out_i),
        .wr_i     (reg_wr_i),
        .wr_arm_i (reg_wdata_i[BIT_CMP]),
        .req_o    (cmp_req)
    );

    rstc_pulse #(.PULSE(PULSE), .WDT_DIV(WDT_DIV)) u_pulse (
        .clk      (clk),
        .por_i    (por_i),
        .start_i  (start),
        .rst_o    (busy),
        .wdt_en_o (wdt_en_o),
        .tick_o   (wdt_tick_o)
    );

    always_comb begin
        req.flash = fl_err;
        req.wdt   = wdt_timeout_i;
        req.sw    = reg_wr_i && reg_wdata_i[BIT_SW];
        req.cmp   = cmp_req;
        start     = !busy && any_req(req);
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            status_q <= '0;
        end else if (start) begin
            status_q <= cause_byte(req);
        end
    end

    assign sys_rst_o = busy;
    assign status_o  = status_q;

    // R7: at most one cause flag is ever set
    p_onehot_status_r7: assert property (@(posedge clk) disable iff (por_i)
        $onehot0(status_q));

    // R8: unused status bits stay clear
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (por_i)
        (status_q & 8'h87) == 8'h00);

    // R9: the status byte holds while the pulse runs
    p_status_hold_r9: assert property (@(posedge clk) disable iff (por_i)
        busy |=> $stable(status_q));

    // R3: an accepted flash error records bit 6
    p_flash_cause_r3: assert property (@(posedge clk) disable iff (por_i)
        (fl_err && !busy) |=> status_q[BIT_FLASH]);

    // R5: software reset without higher sources records bit 4
    p_sw_cause_r5: assert property (@(posedge clk) disable iff (por_i)
        (reg_wr_i && reg_wdata_i[BIT_SW] && !busy && !fl_err && !wdt_timeout_i)
        |=> status_q[BIT_SW]);

    // R4: watchdog timeout without flash error records bit 3
    p_wdt_cause_r4: assert property (@(posedge clk) disable iff (por_i)
        (wdt_timeout_i && !busy && !fl_err) |=> status_q[BIT_WDT]);

endmodule

// File: tb/sim_rst_cause_ctrl.sv
`timescale 1ns/1ps
module sim_rst_cause_ctrl;
    localparam int PULSE   = 16;
    localparam int WDT_DIV = 12;
    localparam int SETTLE  = 2;

    logic        clk = 1'b0;
    logic        por_i = 1'b1;
    logic        cmp_out_i = 1'b1;
    logic        cmp_ready_i = 1'b0;
    logic        wdt_timeout_i = 1'b0;
    logic        fl_valid_i = 1'b0;
    logic [1:0]  fl_kind_i = 2'd3;
    logic        fl_wen_i = 1'b0;
    logic [15:0] fl_addr_i = '0;
    logic        fl_secure_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [7:0]  reg_wdata_i = '0;
    logic        sys_rst_o;
    logic [7:0]  status_o;
    logic        wdt_en_o;
    logic        wdt_tick_o;

    always #2 clk = ~clk;

    rst_cause_ctrl u0 (
        .clk(clk), .por_i(por_i), .cmp_out_i(cmp_out_i), .cmp_ready_i(cmp_ready_i),
        .wdt_timeout_i(wdt_timeout_i), .fl_valid_i(fl_valid_i), .fl_kind_i(fl_kind_i),
        .fl_wen_i(fl_wen_i), .fl_addr_i(fl_addr_i), .fl_secure_i(fl_secure_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .sys_rst_o(sys_rst_o),
        .status_o(status_o), .wdt_en_o(wdt_en_o), .wdt_tick_o(wdt_tick_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Behavioural reference model
    int         m_cnt = PULSE;
    int         m_div = 0;
    int         m_settle = 0;
    bit         m_arm = 0;
    logic [7:0] m_status = 8'h00;
    bit         m_fl, m_wd, m_sw, m_cr, m_settled, m_en_old;

    always @(posedge clk) begin
        cyc++;
        if (por_i) begin
            m_cnt = PULSE; m_status = 8'h00; m_arm = 0; m_div = 0; m_settle = 0;
        end else begin
            m_settled = (m_settle >= SETTLE);
            m_en_old  = (m_cnt == 0);
            m_fl = fl_valid_i &&
                   ((fl_kind_i == 2'd1) || (fl_kind_i == 2'd2) || (fl_kind_i == 2'd0 && fl_wen_i)) &&
                   ((fl_addr_i > 16'h1DFF) || fl_secure_i);
            m_wd = wdt_timeout_i;
            m_sw = reg_wr_i && reg_wdata_i[4];
            m_cr = m_arm && m_settled && !cmp_out_i;
            if (m_cnt != 0) begin
                m_cnt--;
            end else if (m_fl || m_wd || m_sw || m_cr) begin
                m_cnt = PULSE;
                m_arm = 0;
                if (m_fl)      m_status = 8'h40;
                else if (m_wd) m_status = 8'h08;
                else if (m_sw) m_status = 8'h10;
                else           m_status = 8'h20;
            end else if (reg_wr_i) begin
                if (!reg_wdata_i[5])  m_arm = 0;
                else if (m_settled)   m_arm = 1;
            end
            m_div = m_en_old ? ((m_div + 1) % WDT_DIV) : 0;
            if (!cmp_ready_i)        m_settle = 0;
            else if (!m_settled)     m_settle++;
        end
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 sys_rst model", sys_rst_o, (m_cnt != 0));
            chk("R7 status model", status_o, m_status);
            chk("R10 wdt_en model", wdt_en_o, (m_cnt == 0));
            chk("R10 tick model", wdt_tick_o, (m_cnt == 0) && (m_div == WDT_DIV - 1));
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 64 && sys_rst_o; i++) @(negedge clk);
    endtask

    task automatic sw_write(input logic [7:0] d);
        reg_wr_i = 1; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 0; reg_wdata_i = 0;
    endtask

    task automatic flash(input logic [1:0] k, input logic w, input logic [15:0] a, input logic s);
        fl_valid_i = 1; fl_kind_i = k; fl_wen_i = w; fl_addr_i = a; fl_secure_i = s;
        @(negedge clk);
        fl_valid_i = 0; fl_kind_i = 2'd3; fl_wen_i = 0; fl_addr_i = 0; fl_secure_i = 0;
    endtask

    initial begin
        int n;
        int ticks;
        repeat (3) @(negedge clk);
        chk("R1 status in por", status_o, 8'h00);
        chk("R1 rst in por", sys_rst_o, 1);
        por_i = 0;
        n = 0;
        while (sys_rst_o && n < 64) begin n++; @(negedge clk); end
        chk("R1 stretch after por", n, PULSE);
        ticks = 0;
        for (int i = 0; i < 24; i++) begin ticks += wdt_tick_o; @(negedge clk); end
        chk("R10 tick count", ticks, 2);

        // Watchdog source and pulse length
        wdt_timeout_i = 1; @(negedge clk); wdt_timeout_i = 0;
        chk("R4 wdt cause", status_o, 8'h08);
        n = 0;
        while (sys_rst_o && n < 64) begin n++; @(negedge clk); end
        chk("R2 pulse length", n, PULSE);

        sw_write(8'h10);
        chk("R5 sw cause", status_o, 8'h10);
        wait_idle();

        sw_write(8'hCF);
        chk("R8 write ignored status", status_o, 8'h10);
        chk("R8 write no reset", sys_rst_o, 0);

        flash(2'd2, 0, 16'h1DFF, 0);
        flash(2'd0, 0, 16'h3000, 0);
        flash(2'd1, 0, 16'h0100, 0);
        chk("R11 legal no reset", sys_rst_o, 0);
        chk("R11 legal status", status_o, 8'h10);

        flash(2'd1, 0, 16'h1E00, 0);
        chk("R3 code read beyond", status_o, 8'h40);
        wait_idle();
        sw_write(8'h10); wait_idle();
        flash(2'd0, 1, 16'h1E00, 0);
        chk("R3 data write beyond", status_o, 8'h40);
        wait_idle();
        sw_write(8'h10); wait_idle();
        flash(2'd2, 0, 16'h2000, 0);
        chk("R3 fetch beyond", status_o, 8'h40);
        wait_idle();
        sw_write(8'h10); wait_idle();
        flash(2'd1, 0, 16'h0100, 1);
        chk("R3 secure read", status_o, 8'h40);
        wait_idle();

        // Comparator arming before settling
        cmp_out_i = 0; cmp_ready_i = 0;
        sw_write(8'h20);
        repeat (4) @(negedge clk);
        chk("R6 unsettled no arm", sys_rst_o, 0);
        cmp_ready_i = 1;
        @(negedge clk);
        sw_write(8'h20);
        repeat (4) @(negedge clk);
        chk("R6 one edge short", sys_rst_o, 0);
        cmp_out_i = 1;
        sw_write(8'h20);
        @(negedge clk);
        chk("R6 armed high no reset", sys_rst_o, 0);
        cmp_out_i = 0;
        @(negedge clk);
        chk("R6 cmp cause", status_o, 8'h20);
        cmp_out_i = 1;
        wait_idle();

        // Priority cases
        sw_write(8'h20);
        cmp_out_i = 0;
        sw_write(8'h10);
        chk("R7 sw over cmp", status_o, 8'h10);
        cmp_out_i = 1;
        wait_idle();
        wdt_timeout_i = 1; sw_write(8'h10); wdt_timeout_i = 0;
        chk("R7 wdt over sw", status_o, 8'h08);
        wait_idle();
        wdt_timeout_i = 1; reg_wr_i = 1; reg_wdata_i = 8'h10;
        flash(2'd2, 0, 16'hFFFF, 0);
        wdt_timeout_i = 0; reg_wr_i = 0; reg_wdata_i = 0;
        chk("R7 flash over all", status_o, 8'h40);

        // Requests during the pulse
        repeat (3) @(negedge clk);
        wdt_timeout_i = 1; sw_write(8'h10); wdt_timeout_i = 0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R9 status held", status_o, 8'h40);
        chk("R9 no second pulse", sys_rst_o, 0);

        por_i = 1;
        @(negedge clk); @(negedge clk);
        chk("R1 status cleared", status_o, 8'h00);
        por_i = 0;
        wait_idle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule